// File: doc/BRIEF.md
# Operand Effective Address Unit

This block turns the addressing-mode code of a 16-bit-accumulator, 24-bit-address processor instruction into the 24-bit effective address of its operand. It is given the mode, the 24-bit operand field, the 24-bit program counter and the register values (direct base, two index registers, stack pointer and data bank) together with a start pulse. It answers with a one-cycle done pulse and the address.

Most modes are pure arithmetic and finish one cycle after start. Indirect modes first read a two- or three-byte little-endian pointer through a byte-wide read port with a request level and a read-valid strobe of any latency, then add the final index. The register values are captured when start is accepted. Start is only accepted while no pointer fetch is running.

Mode codes (5 bits): 1 direct, 2 direct+X, 3 direct+Y, 4 direct indirect, 5 direct X-indexed indirect, 6 direct indirect Y-indexed, 7 direct long indirect, 8 direct long indirect Y-indexed, 9 absolute, 10 absolute+X, 11 absolute+Y, 12 program-bank absolute, 13 program-bank indirect, 14 program-bank X-indexed indirect, 15 long, 16 long indirect, 17 long+X, 18 stack relative, 19 stack relative indirect Y-indexed, 20 short branch, 21 long branch. Codes 0 and 22 to 31 are unlisted.

Top module: `oper_ea_unit`

## Requirements
- R1: Modes 1, 2, 3 give bank 0 with low word (D + operand[7:0]), (D + X + operand[7:0]) or (D + Y + operand[7:0]), taken mod 2^16. No memory read is made.
- R2: Modes 4 and 5 read a 2-byte pointer, low byte first, at the 16-bit direct address. For mode 4 that address is (D + operand[7:0]) mod 2^16, and for mode 5 it is (D + X + operand[7:0]) mod 2^16. The result is {DB, pointer}.
- R3: Mode 6 reads the pointer as in mode 4. The result is ({DB, pointer} + Y) mod 2^24, so a carry out of bit 15 reaches the bank byte.
- R4: Modes 7 and 8 read a 3-byte pointer (low, middle, high) starting at (D + operand[7:0]) mod 2^16. Mode 7 returns the pointer, and mode 8 returns (pointer + Y) mod 2^24.
- R5: Mode 9 gives {DB, operand[15:0]}. Modes 10 and 11 add X or Y to that value mod 2^24, with the carry reaching the bank.
- R6: Modes 12 and 13 give {PC[23:16], operand[15:0]}. Mode 14 gives {PC[23:16], (operand[15:0] + X) mod 2^16}.
- R7: Modes 15 and 16 return the operand unchanged. Mode 17 returns (operand + X) mod 2^24.
- R8: Mode 18 gives bank 0 with low word (S + operand[7:0]) mod 2^16. Mode 19 reads a 2-byte pointer at that address and gives ({DB, pointer} + Y) mod 2^24.
- R9: Mode 20 computes base = {PC[23:16], (PC[15:0] + 2) mod 2^16} and adds operand[7:0] sign-extended. Mode 21 uses + 3 and operand[15:0] sign-extended. Both sums are taken mod 2^24.
- R10: Codes 0 and 22 to 31 return address 0, with done one cycle after start and no memory request.
- R11: A mode that needs no read raises done in the cycle after the accepted start. Done is high for exactly one cycle, and ea holds its value until the next done.
- R12: Pointer bytes are requested one at a time. mem_req stays high with a stable mem_addr until mem_rvalid. Successive bytes come from the 24-bit addresses base, base+1 and base+2, so a carry from 0xFFFF reaches bank 1. Done follows in the cycle after the final mem_rvalid. mem_rvalid while mem_req is low has no effect.
- R13: Start is ignored while a pointer fetch runs. Register and operand inputs are sampled only at the accepted start, and later changes do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request an address computation |
| mode | input | 5 | Addressing-mode code |
| operand | input | 24 | Operand field of the instruction |
| pc | input | 24 | Program counter of the instruction |
| reg_d | input | 16 | Direct page base |
| reg_x | input | 16 | X index |
| reg_y | input | 16 | Y index |
| reg_s | input | 16 | Stack pointer |
| reg_db | input | 8 | Data bank |
| mem_req | output | 1 | Byte read request, held until read-valid |
| mem_addr | output | 24 | Byte read address |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 24 | Effective address, valid from done onward |

## Verification
Every mode is driven with register values chosen to sit near a wrap point: direct sums that cross 0xFFFF, index adds that carry into the bank, pointers placed at 0xFFFF so the second byte comes from bank 1, and branch displacements of both signs that cross a bank edge. These patterns separate 16-bit wrapping from a full 24-bit carry. The memory model returns a byte that depends on every address bit, so a wrong pointer address or a wrong byte order shows up as a wrong result. Fetches are repeated with zero and multi-cycle read latency. Starts arriving mid-fetch, inputs that change after start, and stray read-valid strobes check that only the accepted start and requested bytes count.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 24;
  localparam int MODE_W    = 5;
  localparam int PTR_MAX   = ADDR_W / BYTE_W;
  localparam int PTR_IDX_W = $clog2(PTR_MAX);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PTR_IDX_W-1:0] plen_t;

  typedef enum logic [MODE_W-1:0] {
    M_NONE       = 5'd0,
    M_DIR        = 5'd1,
    M_DIR_X      = 5'd2,
    M_DIR_Y      = 5'd3,
    M_DIR_IND    = 5'd4,
    M_DIR_X_IND  = 5'd5,
    M_DIR_IND_Y  = 5'd6,
    M_DIR_LIND   = 5'd7,
    M_DIR_LIND_Y = 5'd8,
    M_ABS        = 5'd9,
    M_ABS_X      = 5'd10,
    M_ABS_Y      = 5'd11,
    M_PB_ABS     = 5'd12,
    M_PB_IND     = 5'd13,
    M_PB_X_IND   = 5'd14,
    M_LONG       = 5'd15,
    M_LONG_IND   = 5'd16,
    M_LONG_X     = 5'd17,
    M_STK        = 5'd18,
    M_STK_IND_Y  = 5'd19,
    M_REL8       = 5'd20,
    M_REL16      = 5'd21
  } mode_e;

  typedef struct packed {
    addr_t opnd;
    addr_t pc;
    word_t d;
    word_t x;
    word_t y;
    word_t s;
    byte_t db;
  } ctx_t;

  // 16-bit sum of a base, an index and an 8-bit offset, wrapped in the word
  function automatic word_t wrap16(word_t base, word_t idx, byte_t off);
    return base + idx + word_t'(off);
  endfunction

  function automatic addr_t join_bank(byte_t bank, word_t w);
    return {bank, w};
  endfunction

  // 24-bit add of an unsigned word, carry free to reach the bank byte
  function automatic addr_t carry_add(addr_t base, word_t idx);
    return base + addr_t'(idx);
  endfunction

  function automatic addr_t sext_word(word_t w);
    return {{(ADDR_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction

  function automatic word_t sext_byte(byte_t b);
    return {{(WORD_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

  // Branch target: step within the program bank, then signed 24-bit add
  function automatic addr_t branch_target(addr_t pc, word_t step, word_t disp);
    word_t nxt;
    nxt = pc[WORD_W-1:0] + step;
    return {pc[ADDR_W-1:WORD_W], nxt} + sext_word(disp);
  endfunction

  // Number of pointer bytes a mode reads (0 = pure arithmetic)
  function automatic plen_t ptr_len(logic [MODE_W-1:0] m);
    case (m)
      M_DIR_IND, M_DIR_X_IND, M_DIR_IND_Y, M_STK_IND_Y: return plen_t'(2);
      M_DIR_LIND, M_DIR_LIND_Y:                        return plen_t'(3);
      default:                                         return plen_t'(0);
    endcase
  endfunction

  // Address of the first pointer byte
  function automatic addr_t ptr_base(logic [MODE_W-1:0] m, ctx_t c);
    word_t w;
    case (m)
      M_DIR_X_IND: w = wrap16(c.d, c.x, c.opnd[BYTE_W-1:0]);
      M_STK_IND_Y: w = wrap16(c.s, '0, c.opnd[BYTE_W-1:0]);
      default:     w = wrap16(c.d, '0, c.opnd[BYTE_W-1:0]);
    endcase
    return join_bank('0, w);
  endfunction

  // Result of the modes that need no memory read
  function automatic addr_t arith_ea(logic [MODE_W-1:0] m, ctx_t c);
    byte_t pbank;
    byte_t o8;
    word_t o16;
    pbank = c.pc[ADDR_W-1:WORD_W];
    o8    = c.opnd[BYTE_W-1:0];
    o16   = c.opnd[WORD_W-1:0];
    case (m)
      M_DIR:      return join_bank('0, wrap16(c.d, '0, o8));
      M_DIR_X:    return join_bank('0, wrap16(c.d, c.x, o8));
      M_DIR_Y:    return join_bank('0, wrap16(c.d, c.y, o8));
      M_ABS:      return join_bank(c.db, o16);
      M_ABS_X:    return carry_add(join_bank(c.db, o16), c.x);
      M_ABS_Y:    return carry_add(join_bank(c.db, o16), c.y);
      M_PB_ABS,
      M_PB_IND:   return join_bank(pbank, o16);
      M_PB_X_IND: return join_bank(pbank, o16 + c.x);
      M_LONG,
      M_LONG_IND: return c.opnd;
      M_LONG_X:   return carry_add(c.opnd, c.x);
      M_STK:      return join_bank('0, wrap16(c.s, '0, o8));
      M_REL8:     return branch_target(c.pc, word_t'(2), sext_byte(o8));
      M_REL16:    return branch_target(c.pc, word_t'(3), o16);
      default:    return '0;
    endcase
  endfunction

  // Result of the modes that read a pointer
  function automatic addr_t fetch_ea(logic [MODE_W-1:0] m, ctx_t c, addr_t p);
    case (m)
      M_DIR_IND, M_DIR_X_IND:   return join_bank(c.db, p[WORD_W-1:0]);
      M_DIR_IND_Y, M_STK_IND_Y: return carry_add(join_bank(c.db, p[WORD_W-1:0]), c.y);
      M_DIR_LIND:               return p;
      M_DIR_LIND_Y:             return carry_add(p, c.y);
      default:                  return '0;
    endcase
  endfunction
endpackage

// File: rtl/ea_mode_class.sv
module ea_mode_class
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  ctx_t              ctx,
  output logic              needs_fetch,
  output plen_t             len,
  output addr_t             base,
  output addr_t             quick_ea
);
  always_comb begin
    len         = ptr_len(mode);
    needs_fetch = (len != '0);
    base        = ptr_base(mode, ctx);
    quick_ea    = arith_ea(mode, ctx);
  end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
  import ea_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  addr_t base,
  input  plen_t len,
  output logic  busy,
  output logic  mem_req,
  output addr_t mem_addr,
  input  logic  mem_rvalid,
  input  byte_t mem_rdata,
  output logic  beat,
  output logic  last,
  output addr_t ptr
);
  logic  busy_q;
  plen_t idx_q;
  plen_t len_q;
  addr_t base_q;
  byte_t byte_q [PTR_MAX];
  byte_t lane   [PTR_MAX];

  assign busy     = busy_q;
  assign mem_req  = busy_q;
  assign mem_addr = base_q + addr_t'(idx_q);
  assign beat     = busy_q && mem_rvalid;
  assign last     = beat && (plen_t'(idx_q + 1'b1) == len_q);

  // Each lane forwards the arriving byte so the pointer is whole on the last beat
  for (genvar i = 0; i < PTR_MAX; i++) begin : g_lane
    assign lane[i] = (beat && idx_q == plen_t'(i)) ? mem_rdata : byte_q[i];
  end

  always_comb begin
    ptr = '0;
    for (int i = 0; i < PTR_MAX; i++) begin
      ptr[i*BYTE_W +: BYTE_W] = lane[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      base_q <= '0;
      for (int i = 0; i < PTR_MAX; i++) byte_q[i] <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      len_q  <= len;
      base_q <= base;
      for (int i = 0; i < PTR_MAX; i++) byte_q[i] <= '0;
    end else if (beat) begin
      byte_q[idx_q] <= mem_rdata;
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/ea_finish.sv
module ea_finish
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  ctx_t              ctx,
  input  addr_t             ptr,
  output addr_t             final_ea
);
  always_comb final_ea = fetch_ea(mode, ctx, ptr);
endmodule

// File: rtl/oper_ea_unit.sv
module oper_ea_unit
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] pc,
  input  logic [WORD_W-1:0] reg_d,
  input  logic [WORD_W-1:0] reg_x,
  input  logic [WORD_W-1:0] reg_y,
  input  logic [WORD_W-1:0] reg_s,
  input  logic [BYTE_W-1:0] reg_db,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] ea
);
  ctx_t              ctx_in;
  ctx_t              ctx_q;
  logic [MODE_W-1:0] mode_q;
  logic              fetch_busy;
  logic              accept;
  logic              need_fetch;
  plen_t             len;
  addr_t             base;
  addr_t             quick_ea;
  logic              launch;
  logic              fetch_beat;
  logic              fetch_last;
  addr_t             ptr_full;
  addr_t             slow_ea;
  addr_t             ea_q;
  logic              done_q;

  assign ctx_in = '{opnd: operand, pc: pc, d: reg_d, x: reg_x,
                    y: reg_y, s: reg_s, db: reg_db};
  assign accept = start && !fetch_busy;
  assign launch = accept && need_fetch;

  ea_mode_class u_class (
    .mode        (mode),
    .ctx         (ctx_in),
    .needs_fetch (need_fetch),
    .len         (len),
    .base        (base),
    .quick_ea    (quick_ea)
  );

  ea_ptr_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .base       (base),
    .len        (len),
    .busy       (fetch_busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .beat       (fetch_beat),
    .last       (fetch_last),
    .ptr        (ptr_full)
  );

  ea_finish u_finish (
    .mode     (mode_q),
    .ctx      (ctx_q),
    .ptr      (ptr_full),
    .final_ea (slow_ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctx_q  <= '0;
      ea_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        mode_q <= mode;
        ctx_q  <= ctx_in;
        if (!need_fetch) begin
          ea_q   <= quick_ea;
          done_q <= 1'b1;
        end
      end
      if (fetch_last) begin
        ea_q   <= slow_ea;
        done_q <= 1'b1;
      end
    end
  end

  assign done = done_q;
  assign ea   = ea_q;
endmodule

// File: rtl/oper_ea_unit_checker.sv
module oper_ea_unit_checker
  import ea_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [MODE_W-1:0] mode,
  input logic [ADDR_W-1:0] operand,
  input logic [WORD_W-1:0] reg_d,
  input logic              done,
  input logic [ADDR_W-1:0] ea,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              accept,
  input logic              need_fetch,
  input logic              fetch_last
);
  assert_direct_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode == M_DIR |=> ea[ADDR_W-1:WORD_W] == '0 &&
      ea[WORD_W-1:0] == WORD_W'($past(reg_d) + WORD_W'($past(operand[BYTE_W-1:0]))));

  assert_unlisted_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (mode == M_NONE || mode > M_REL16) |=> done && ea == '0 && !mem_req);

  assert_quick_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !need_fetch |=> done);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ea_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  assert_addr_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid && !fetch_last |=> mem_req && mem_addr == $past(mem_addr) + 1'b1);

  assert_done_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_last |=> done && !mem_req);

  assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start && mem_req && !fetch_last |=> !done);
endmodule

bind oper_ea_unit oper_ea_unit_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .mode       (mode),
  .operand    (operand),
  .reg_d      (reg_d),
  .done       (done),
  .ea         (ea),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .accept     (accept),
  .need_fetch (need_fetch),
  .fetch_last (fetch_last)
);

// File: tb/oper_ea_unit_test.sv
module oper_ea_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  mode = '0;
  logic [23:0] operand = '0;
  logic [23:0] pc = '0;
  logic [15:0] reg_d = '0, reg_x = '0, reg_y = '0, reg_s = '0;
  logic [7:0]  reg_db = '0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [23:0] ea;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int wcnt = 0;
  int nbytes = 0;
  bit stray = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oper_ea_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .operand(operand),
    .pc(pc), .reg_d(reg_d), .reg_x(reg_x), .reg_y(reg_y), .reg_s(reg_s),
    .reg_db(reg_db), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .ea(ea)
  );

  // Memory contents: every address bit influences the byte
  function automatic logic [7:0] memf(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  function automatic int rd2(int a);
    return int'(memf(24'(a))) + 256 * int'(memf(24'(a + 1)));
  endfunction

  function automatic int rd3(int a);
    return rd2(a) + 65536 * int'(memf(24'(a + 2)));
  endfunction

  // Expected address, written from the requirement text
  function automatic logic [23:0] model(int m, logic [23:0] op, logic [23:0] p,
      logic [15:0] d, logic [15:0] x, logic [15:0] y, logic [15:0] s, logic [7:0] db);
    int o8 = int'(op[7:0]);
    int o16 = int'(op[15:0]);
    int o24 = int'(op);
    int pb = int'(p[23:16]) * 65536;
    int pl = int'(p[15:0]);
    int dd = int'(d), xx = int'(x), yy = int'(y), ss = int'(s);
    int bank = int'(db) * 65536;
    int r = 0;
    int a = (dd + o8) % 65536;
    case (m)
      1:  r = a;
      2:  r = (dd + xx + o8) % 65536;
      3:  r = (dd + yy + o8) % 65536;
      4:  r = bank + rd2(a);
      5:  r = bank + rd2((dd + xx + o8) % 65536);
      6:  r = bank + rd2(a) + yy;
      7:  r = rd3(a);
      8:  r = rd3(a) + yy;
      9:  r = bank + o16;
      10: r = bank + o16 + xx;
      11: r = bank + o16 + yy;
      12, 13: r = pb + o16;
      14: r = pb + (o16 + xx) % 65536;
      15, 16: r = o24;
      17: r = o24 + xx;
      18: r = (ss + o8) % 65536;
      19: r = bank + rd2((ss + o8) % 65536) + yy;
      20: r = pb + (pl + 2) % 65536 + (o8 >= 128 ? o8 - 256 : o8);
      21: r = pb + (pl + 3) % 65536 + (o16 >= 32768 ? o16 - 65536 : o16);
      default: r = 0;
    endcase
    return 24'(r & 32'h00FF_FFFF);
  endfunction

  // Memory responder with programmable latency
  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memf(mem_addr);
        wcnt       = 0;
      end else begin
        mem_rvalid = 1'b0;
        wcnt       = wcnt + 1;
      end
    end else begin
      mem_rvalid = stray;
      mem_rdata  = 8'hEE;
      wcnt       = 0;
    end
  end

  always @(posedge clk) if (mem_req && mem_rvalid) nbytes <= nbytes + 1;

  task automatic chk(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(int m, logic [23:0] op, logic [23:0] p, logic [15:0] d,
      logic [15:0] x, logic [15:0] y, logic [15:0] s, logic [7:0] db,
      int nb, string tag);
    logic [23:0] exp;
    int cyc;
    exp = model(m, op, p, d, x, y, s, db);
    @(negedge clk);
    mode = 5'(m); operand = op; pc = p; reg_d = d; reg_x = x; reg_y = y;
    reg_s = s; reg_db = db; start = 1'b1; nbytes = 0;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, {tag, " done seen"}, 24'(done), 24'd1);
    chk(ea == exp, {tag, " address"}, ea, exp);
    chk(nbytes == nb, {tag, " byte reads"}, 24'(nbytes), 24'(nb));
    if (nb == 0) chk(cyc == 1, {tag, " R11 latency"}, 24'(cyc), 24'd1);
    @(negedge clk);
    chk(done == 1'b0 && ea == exp, {tag, " R11 pulse/hold"}, ea, exp);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R11 reset done", 24'(done), 24'd0);
    chk(mem_req == 1'b0, "R12 reset req", 24'(mem_req), 24'd0);
    chk(ea == '0, "R11 reset ea", ea, 24'd0);
  endtask

  task automatic t_direct;
    run_op(1, 24'h000020, 24'h0, 16'hFFF0, 16'h0, 16'h0, 16'h0, 8'h7E, 0, "R1 dir wrap");
    run_op(2, 24'h000090, 24'h0, 16'hFF00, 16'h0180, 16'h0, 16'h0, 8'h7E, 0, "R1 dir+X wrap");
    run_op(3, 24'h1234F1, 24'h0, 16'h0100, 16'h0, 16'h0203, 16'h0, 8'h10, 0, "R1 dir+Y");
  endtask

  task automatic t_dir_ind;
    run_op(4, 24'h000045, 24'h0, 16'h2000, 16'h0, 16'h0, 16'h0, 8'h3C, 2, "R2 dir ind");
    run_op(5, 24'h000010, 24'h0, 16'hFF00, 16'h00EF, 16'h0, 16'h0, 8'h81, 2, "R2 dir X ind bank cross");
  endtask

  task automatic t_dir_ind_y;
    run_op(6, 24'h000033, 24'h0, 16'h0400, 16'h0, 16'hFFFF, 16'h0, 8'hFF, 2, "R3 ind Y carry");
    run_op(6, 24'h000002, 24'h0, 16'h1000, 16'h0, 16'h0001, 16'h0, 8'h05, 2, "R3 ind Y small");
  endtask

  task automatic t_long_ind;
    run_op(7, 24'h0000FE, 24'h0, 16'hFF01, 16'h0, 16'h0, 16'h0, 8'h00, 3, "R4 long ind");
    run_op(8, 24'h000070, 24'h0, 16'h3300, 16'h0, 16'hF00F, 16'h0, 8'h00, 3, "R4 long ind Y");
  endtask

  task automatic t_abs;
    run_op(9, 24'hAAC123, 24'h0, 16'h0, 16'h0, 16'h0, 16'h0, 8'h12, 0, "R5 abs");
    run_op(10, 24'h00FFF0, 24'h0, 16'h0, 16'h0020, 16'h0, 16'h0, 8'hFF, 0, "R5 abs X top wrap");
    run_op(11, 24'h008000, 24'h0, 16'h0, 16'h0, 16'h9000, 16'h0, 8'h01, 0, "R5 abs Y carry");
  endtask

  task automatic t_pbank;
    run_op(12, 24'h55BEEF, 24'h7F1234, 16'h0, 16'h0, 16'h0, 16'h0, 8'h22, 0, "R6 pb abs");
    run_op(13, 24'h001000, 24'h030000, 16'h0, 16'h0, 16'h0, 16'h0, 8'h22, 0, "R6 pb ind");
    run_op(14, 24'h00FFF0, 24'h400000, 16'h0, 16'h0030, 16'h0, 16'h0, 8'h22, 0, "R6 pb X ind wrap");
  endtask

  task automatic t_long;
    run_op(15, 24'hC01234, 24'h0, 16'h0, 16'h5555, 16'h0, 16'h0, 8'h0, 0, "R7 long");
    run_op(16, 24'h7E8000, 24'h0, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 0, "R7 long ind");
    run_op(17, 24'hFFFFF0, 24'h0, 16'h0, 16'h0020, 16'h0, 16'h0, 8'h0, 0, "R7 long X wrap");
  endtask

  task automatic t_stack;
    run_op(18, 24'h0000F0, 24'h0, 16'h0, 16'h0, 16'h0, 16'hFFF0, 8'h0, 0, "R8 stk wrap");
    run_op(19, 24'h000003, 24'h0, 16'h0, 16'h0, 16'h8001, 16'h01F0, 8'hFE, 2, "R8 stk ind Y");
  endtask

  task automatic t_rel;
    run_op(20, 24'h000010, 24'h12FFFE, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 0, "R9 short fwd bank wrap");
    run_op(20, 24'h000080, 24'h120010, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 0, "R9 short back cross");
    run_op(21, 24'h00F000, 24'h000100, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 0, "R9 long back bank0");
    run_op(21, 24'h007FFF, 24'h05FFFD, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 0, "R9 long fwd");
  endtask

  task automatic t_unlisted;
    run_op(0, 24'h123456, 24'h654321, 16'h1, 16'h2, 16'h3, 16'h4, 8'h5, 0, "R10 code 0");
    run_op(22, 24'h123456, 24'h654321, 16'h1, 16'h2, 16'h3, 16'h4, 8'h5, 0, "R10 code 22");
    run_op(31, 24'hFFFFFF, 24'hFFFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'hFF, 0, "R10 code 31");
  endtask

  task automatic t_latency;
    lat = 3;
    run_op(4, 24'h0000FF, 24'h0, 16'hFF00, 16'h0, 16'h0, 16'h0, 8'h9A, 2, "R12 slow bank1 byte");
    run_op(8, 24'h000001, 24'h0, 16'hFFFE, 16'h0, 16'h00FF, 16'h0, 8'h0, 3, "R12 slow long ind");
    lat = 0;
  endtask

  task automatic t_stray;
    logic [23:0] held;
    held = ea;
    @(negedge clk);
    stray = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(done == 1'b0 && mem_req == 1'b0, "R12 stray rvalid no done", 24'(done), 24'd0);
    end
    stray = 1'b0;
    chk(ea == held, "R12 stray rvalid ea held", ea, held);
  endtask

  task automatic t_busy;
    logic [23:0] exp;
    int cyc;
    lat = 4;
    exp = model(4, 24'h000011, 24'h0, 16'h2200, 16'h0, 16'h0, 16'h0, 8'h44);
    @(negedge clk);
    mode = 5'd4; operand = 24'h000011; reg_d = 16'h2200; reg_db = 8'h44;
    start = 1'b1; nbytes = 0;
    @(negedge clk);
    start = 1'b0;
    mode = 5'd15; operand = 24'h999999; reg_d = 16'h0000; reg_db = 8'h00;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R13 start during fetch ignored", 24'(done), 24'd0);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(ea == exp, "R13 result from sampled inputs", ea, exp);
    chk(nbytes == 2, "R13 byte reads", 24'(nbytes), 24'd2);
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b0, "R13 no second done", 24'(done), 24'd0);
    end
    lat = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog R11 act=timeout exp=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_dir_ind();
    t_dir_ind_y();
    t_long_ind();
    t_abs();
    t_pbank();
    t_long();
    t_stack();
    t_rel();
    t_unlisted();
    t_latency();
    t_stray();
    t_busy();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule